// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave

This block is a two-wire serial slave that keeps six 8-bit configuration registers, for example the per-output enable bits of a clock generator. It sits on the SCL/SDA bus, samples both lines with a much faster system clock, detects START and STOP, matches its device address and pulls SDA low for ACK and for data bits. The six registers are always visible on a parallel bus for the surrounding logic.

Software cannot address a single register. A write always carries two leading bytes, a command byte and a count byte. Both are acknowledged and then thrown away. The data bytes that follow fill register 0 upward, and the host may stop after any whole byte. A read returns a count byte first and then every register in ascending order, until the host answers with NACK.

The control path is one state machine. Its states are:

- ST_IDLE: the bus is free.
- ST_ADDR: the address byte is shifting in.
- ST_ADDR_ACK: ACK is driven for the address.
- ST_WR_BYTE: a write byte is shifting in.
- ST_WR_ACK: ACK is driven for a write byte.
- ST_RD_BYTE: a read byte is shifting out.
- ST_RD_ACK: the host's acknowledge is being sampled.
- ST_WAIT: the slave stays silent until the next START or STOP.

Its transitions are:

- A STOP from any state leads to ST_IDLE.
- A START from any state leads to ST_ADDR.
- From ST_ADDR, on the SCL fall after eight address bits, the machine goes to ST_ADDR_ACK on a match and to ST_WAIT on a mismatch.
- From ST_ADDR_ACK, on the next SCL fall, it goes to ST_RD_BYTE or ST_WR_BYTE as the R/W bit selects.
- From ST_WR_BYTE, on the SCL fall after eight bits, it goes to ST_WR_ACK.
- From ST_WR_ACK, on the next SCL fall, it returns to ST_WR_BYTE.
- From ST_RD_BYTE, on the SCL fall that ends bit 0, it goes to ST_RD_ACK.
- From ST_RD_ACK, on the next SCL fall, it goes to ST_RD_BYTE if the host sent ACK and to ST_WAIT if the host sent NACK.

Top module: `cfg_block_slave`

## Requirements
- R1: After reset every register reads 0xFF and the slave does not pull SDA.
- R2: The slave acknowledges the address byte 0xD2 (write) and the address byte 0xD3 (read). The upper seven bits are the device address 0x69 and bit 0 is R/W, with 1 meaning read. Bytes travel MSB first, and ACK is SDA low during the ninth clock.
- R3: Any other address byte gets no ACK. The slave then drives nothing until the next START, and the registers stay unchanged.
- R4: In a write, the first two bytes after the address are acknowledged and have no effect on any register.
- R5: Each following data byte is acknowledged and loads the registers in ascending order, starting at register 0. Register k appears on cfg_o[8k+7:8k].
- R6: A STOP after any complete byte keeps the registers already written and leaves the remaining registers unchanged.
- R7: Data bytes beyond register 5 are acknowledged and ignored.
- R8: A byte cut short by STOP or START changes no register.
- R9: A read returns the count byte 0x06, then registers 0 to 5. Any byte requested after register 5 reads as 0xFF.
- R10: After the host NACKs a read byte, the slave releases SDA and keeps it released until the next START.
- R11: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START in the middle of any byte restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |
| cfg_o | output | 8*NUM_REGS | All registers, register k on bits [8k+7:8k] |

## Verification
The assertions assume three things about the bus:

- SDA moves only while SCL is low, except for START and STOP.
- Each SCL phase lasts well beyond the synchronizer and edge-detector latency.
- The host never stretches or glitches SCL.

The stimulus holds to this. The host model runs each bit as four quarter-phases of eight system clocks. It changes SDA only a full quarter after SCL has fallen, and it builds START and STOP with SCL held high for a full quarter. Write lengths, partial trailing bits, read lengths and wrong addresses are drawn at random from a fixed seed, on top of directed cases for interrupted bytes, the NACK release and reads past the last register.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT
    } cbs_state_t;

endpackage

// File: rtl/cbs_linesync.sv
module cbs_linesync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);

    // Each line gets its own flop chain; the bus idles high, so the chain resets to 1.
    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], din[l]};
            end
        end

        assign dout[l] = chain[STAGES-1];
    end

endmodule

// File: rtl/cbs_busevent.sv
module cbs_busevent (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        // START and STOP require SCL high both before and after the SDA edge.
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/cbs_regbank.sv
module cbs_regbank #(
    parameter int          NUM_REGS = 6,
    parameter int          IDX_W    = 3,
    parameter logic [7:0]  RST_VAL  = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [8*NUM_REGS-1:0] regs_flat
);

    logic [7:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= RST_VAL;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                mem[g] <= wr_data;
            end
        end

        assign regs_flat[8*g +: 8] = mem[g];
    end

    // An index past the last register reads as all ones, which is an idle bus byte.
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = mem[i];
            end
        end
    end

endmodule

// File: rtl/cfg_block_slave.sv
module cfg_block_slave #(
    parameter int          NUM_REGS    = 6,
    parameter int          SKIP_BYTES  = 2,
    parameter int          SYNC_STAGES = 2,
    parameter logic [6:0]  DEV_ADDR    = 7'h69,
    parameter logic [7:0]  RST_VAL     = 8'hFF,
    parameter logic [7:0]  READ_COUNT  = 8'd6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    output logic [8*NUM_REGS-1:0] cfg_o
);

    import cbs_pkg::*;

    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int BIDX_W = $clog2(SKIP_BYTES + NUM_REGS + 1);
    localparam int RIDX_W = $clog2(NUM_REGS + 1);
    localparam logic [BIDX_W-1:0] BIDX_MAX   = '1;
    localparam logic [BIDX_W-1:0] FIRST_DATA = BIDX_W'(SKIP_BYTES);
    localparam logic [BIDX_W-1:0] PAST_DATA  = BIDX_W'(SKIP_BYTES + NUM_REGS);
    localparam logic [RIDX_W-1:0] RIDX_END   = RIDX_W'(NUM_REGS);
    localparam logic [CNT_W-1:0]  LAST_TX    = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0]  FULL_RX    = CNT_W'(BYTE_W);

    // ---------------- line conditioning ----------------
    logic [1:0] lines_s;
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;

    cbs_linesync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    cbs_busevent u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // ---------------- state and datapath registers ----------------
    cbs_state_t        state;
    cbs_state_t        state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BIDX_W-1:0] byte_idx;
    logic [RIDX_W-1:0] rd_idx;
    logic              host_ack;
    logic              sda_pull;

    logic              addr_hit;
    logic              rx_done;
    logic              wr_en;
    logic [RIDX_W-1:0] wr_idx;
    logic [7:0]        rd_data;

    assign addr_hit = (rx_sh[BYTE_W-1:1] == DEV_ADDR);
    assign rx_done  = scl_fall && (bit_cnt == FULL_RX);
    assign wr_en    = (state == ST_WR_BYTE) && rx_done &&
                      (byte_idx >= FIRST_DATA) && (byte_idx < PAST_DATA);
    assign wr_idx   = RIDX_W'(byte_idx - FIRST_DATA);

    cbs_regbank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (RIDX_W),
        .RST_VAL  (RST_VAL)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (rx_sh),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_flat (cfg_o)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nx = ST_IDLE;
                end
                ST_ADDR: begin
                    if (rx_done) begin
                        state_nx = addr_hit ? ST_ADDR_ACK : ST_WAIT;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        state_nx = rx_sh[0] ? ST_RD_BYTE : ST_WR_BYTE;
                    end
                end
                ST_WR_BYTE: begin
                    if (rx_done) begin
                        state_nx = ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        state_nx = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall && (bit_cnt == LAST_TX)) begin
                        state_nx = ST_RD_ACK;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_fall) begin
                        state_nx = host_ack ? ST_RD_BYTE : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    state_nx = ST_WAIT;
                end
            endcase
        end
    end

    // ---------------- datapath and output process ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            byte_idx <= '0;
            rd_idx   <= '0;
            host_ack <= 1'b0;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else if (start_det) begin
            bit_cnt  <= '0;
            byte_idx <= '0;
            sda_pull <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                    if (rx_done) begin
                        if (state == ST_ADDR) begin
                            sda_pull <= addr_hit;
                        end else begin
                            sda_pull <= 1'b1;
                            if (byte_idx != BIDX_MAX) begin
                                byte_idx <= byte_idx + BIDX_W'(1);
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt  <= '0;
                        byte_idx <= '0;
                        rd_idx   <= '0;
                        if (rx_sh[0]) begin
                            tx_sh    <= READ_COUNT;
                            sda_pull <= ~READ_COUNT[BYTE_W-1];
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt  <= '0;
                        sda_pull <= 1'b0;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST_TX) begin
                            sda_pull <= 1'b0;
                        end else begin
                            tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_pull <= ~tx_sh[BYTE_W-2];
                            bit_cnt  <= bit_cnt + CNT_W'(1);
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_s;
                    end
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (host_ack) begin
                            tx_sh    <= rd_data;
                            sda_pull <= ~rd_data[BYTE_W-1];
                            if (rd_idx != RIDX_END) begin
                                rd_idx <= rd_idx + RIDX_W'(1);
                            end
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end
                end
                ST_IDLE, ST_WAIT: begin
                    sda_pull <= 1'b0;
                end
            endcase
        end
    end

    assign sda_pull_o = sda_pull;

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
    parameter int NUM_REGS = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sda_pull_o,
    input logic [8*NUM_REGS-1:0] cfg_o,
    input cbs_pkg::cbs_state_t   state,
    input logic                  scl_fall,
    input logic                  start_det,
    input logic                  stop_det,
    input logic                  wr_en
);

    import cbs_pkg::*;

    // R5: the register bus moves only after a committed data byte
    a_r5_cfg_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_o));

    // R2: the SDA pull changes only in reaction to an SCL fall or a bus condition
    a_r2_pull_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> $past(scl_fall || start_det || stop_det));

    // R1: a free bus is never pulled
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull_o);

    // R10 and R3: the silent state never pulls SDA
    a_r10_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_pull_o);

    // R11: STOP frees the bus on the next cycle
    a_r11_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE) && !sda_pull_o);

    // R11: START restarts the address phase from any state
    a_r11_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_ADDR) && !sda_pull_o);

endmodule

bind cfg_block_slave cbs_checker #(
    .NUM_REGS (NUM_REGS)
) u_cbs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_pull_o (sda_pull_o),
    .cfg_o      (cfg_o),
    .state      (state),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .wr_en      (wr_en)
);

// File: tb/tb_cfg_block_slave.sv
module tb_cfg_block_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int NREG       = 6;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic            rst_n;
    logic            host_scl;
    logic            host_sda;
    logic            sda_pull;
    logic            sda_line;
    logic [8*NREG-1:0] cfg;

    assign sda_line = host_sda & ~sda_pull;

    cfg_block_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (host_scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .cfg_o      (cfg)
    );

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    logic [7:0] model [NREG];
    logic [7:0] wbuf  [10];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [8*NREG-1:0] model_bus();
        logic [8*NREG-1:0] r;
        for (int k = 0; k < NREG; k++) r[8*k +: 8] = model[k];
        return r;
    endfunction

    function automatic logic [7:0] read_expect(input int pos);
        if (pos == 0) return 8'd6;
        if (pos - 1 < NREG) return model[pos-1];
        return 8'hFF;
    endfunction

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; waitq(Q);
        host_scl = 1'b1; waitq(Q);
        host_sda = 1'b0; waitq(Q);
        host_scl = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; waitq(Q);
        host_scl = 1'b1; waitq(Q);
        host_sda = 1'b1; waitq(Q);
    endtask

    task automatic send_bit(input bit b);
        host_sda = b;    waitq(Q);
        host_scl = 1'b1; waitq(2*Q);
        host_scl = 1'b0; waitq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit nack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        host_sda = 1'b1; waitq(Q);
        host_scl = 1'b1; waitq(Q);
        nack = sda_line; waitq(Q);
        host_scl = 1'b0; waitq(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        host_sda = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            waitq(Q);
            host_scl = 1'b1; waitq(Q);
            b = {b[6:0], sda_line}; waitq(Q);
            host_scl = 1'b0;
        end
        waitq(Q);
        host_sda = give_ack ? 1'b0 : 1'b1; waitq(Q);
        host_scl = 1'b1; waitq(2*Q);
        host_scl = 1'b0; waitq(Q);
        host_sda = 1'b1;
    endtask

    task automatic wr_txn(input int n, input int pbits, input bit cut_start, input string tag);
        bit nk;
        bus_start();
        send_byte(8'hD2, nk);
        chk(nk == 1'b0, "R2 write address ack", 64'(nk), 64'd0);
        send_byte(8'($urandom), nk);
        chk(nk == 1'b0, "R4 command byte ack", 64'(nk), 64'd0);
        send_byte(8'($urandom), nk);
        chk(nk == 1'b0, "R4 count byte ack", 64'(nk), 64'd0);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], nk);
            chk(nk == 1'b0, (i < NREG) ? "R5 data byte ack" : "R7 extra byte ack", 64'(nk), 64'd0);
            if (i < NREG) model[i] = wbuf[i];
        end
        for (int j = 0; j < pbits; j++) send_bit(1'($urandom));
        if (cut_start) bus_start();
        bus_stop();
        waitq(4);
        chk(cfg == model_bus(), tag, 64'(cfg), 64'(model_bus()));
    endtask

    task automatic rd_txn(input int n);
        bit nk;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, nk);
        chk(nk == 1'b0, "R2 read address ack", 64'(nk), 64'd0);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i < n - 1);
            chk(b == read_expect(i), "R9 read byte", 64'(b), 64'(read_expect(i)));
        end
        bus_stop();
    endtask

    task automatic bad_txn(input logic [7:0] a);
        bit nk;
        bus_start();
        send_byte(a, nk);
        chk(nk == 1'b1, "R3 foreign address nack", 64'(nk), 64'd1);
        send_byte(8'h00, nk);
        chk(nk == 1'b1, "R3 silent after mismatch", 64'(nk), 64'd1);
        bus_stop();
        waitq(4);
        chk(cfg == model_bus(), "R3 registers kept", 64'(cfg), 64'(model_bus()));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [7:0]  b;
        logic [7:0]  a;
        bit          nk;
        seed = $urandom(32'd48151);
        rst_n    = 1'b0;
        host_scl = 1'b1;
        host_sda = 1'b1;
        for (int k = 0; k < NREG; k++) model[k] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        waitq(4);

        // R1 reset state
        chk(cfg == {NREG{8'hFF}}, "R1 reset registers", 64'(cfg), 64'({NREG{8'hFF}}));
        chk(sda_pull == 1'b0, "R1 reset SDA released", 64'(sda_pull), 64'd0);

        // R1 with R9: defaults read back
        rd_txn(7);

        // R5 full block write, then read back
        for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'h11 * i + 8'h03);
        wr_txn(6, 0, 1'b0, "R5 full block write");
        rd_txn(7);

        // R6 early stop after two data bytes
        wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
        wr_txn(2, 0, 1'b0, "R6 early stop keeps rest");

        // R4 prefix only: no data byte written
        wr_txn(0, 0, 1'b0, "R4 prefix bytes discarded");

        // R7 bytes beyond the last register
        for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'hC0 + i);
        wr_txn(8, 0, 1'b0, "R7 extra bytes ignored");

        // R8 partial byte cut by STOP and by START
        for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'h20 + i);
        wr_txn(3, 5, 1'b0, "R8 partial byte before stop");
        wbuf[0] = 8'h7E;
        wr_txn(1, 3, 1'b1, "R8 partial byte before start");

        // R9 read past the last register
        rd_txn(9);

        // R3 foreign addresses, including one bit away
        bad_txn(8'hA0);
        bad_txn(8'hD0);

        // R11 START in the middle of the address byte restarts decoding
        bus_start();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        wbuf[0] = 8'h3C;
        wr_txn(1, 0, 1'b0, "R11 restart mid-address");

        // R10 NACK of the count byte: the next byte must stay released
        wbuf[0] = 8'h00;
        wr_txn(1, 0, 1'b0, "R5 zero into register 0");
        bus_start();
        send_byte(8'hD3, nk);
        chk(nk == 1'b0, "R2 read address ack", 64'(nk), 64'd0);
        recv_byte(b, 1'b0);
        chk(b == 8'd6, "R9 count byte", 64'(b), 64'd6);
        recv_byte(b, 1'b0);
        chk(b == 8'hFF, "R10 released after nack", 64'(b), 64'hFF);
        chk(sda_pull == 1'b0, "R10 no pull after nack", 64'(sda_pull), 64'd0);
        bus_stop();

        // Random mix
        for (int t = 0; t < 20; t++) begin
            int kind;
            kind = int'($urandom % 6);
            if (kind == 0) begin
                a = 8'($urandom);
                if (a[7:1] == 7'h69) a = a ^ 8'h10;
                bad_txn(a);
            end else if (kind <= 2) begin
                rd_txn(1 + int'($urandom % 8));
            end else begin
                int n;
                int p;
                n = int'($urandom % 9);
                p = int'($urandom % 4);
                for (int i = 0; i < 10; i++) wbuf[i] = 8'($urandom);
                wr_txn(n, p, 1'($urandom), "R6 random block write");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule